// File: doc/BRIEF.md
# Dipulse Bit-Cell Receive Sampler

This block turns a pulse-coded serial receive line back into data bits. The line carries one bit per fixed-length cell. A positive pulse inside a cell means 1, and a cell with no pulse means 0. The line input is asynchronous to the system clock, so the block synchronizes it, detects rising edges, and decodes cell contents against a local cell grid. At the default 20 MHz system clock, one 400 ns cell is 8 clocks, and a pulse may arrive up to 100 ns (2 clocks) away from its nominal position.

The grid is idle until the first pulse after enable. That pulse sets the grid's phase so that it sits at the nominal mid-cell position. After that, the first in-window pulse of each cell re-centres the grid, so slow drift of the sender's clock is followed. At every cell end the block emits a one-clock valid strobe carrying the cell's bit. A pulse that lands outside the tolerance window raises a one-clock error flag and is not decoded as a 1. Framing, byte assembly, CRC and carrier sensing are left to later stages.

Top module: `rxDipulseSampler`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `bitValid`, `bitData` and `pulseErr` are all 0.
- R2: After enable, no valid strobe and no error appear until the first rising edge of `rxPulse` has locked the grid.
- R3: The locking pulse decodes its own cell as 1. With default parameters, `bitValid` for that cell is high at the sixth rising clock edge after `rxPulse` rises.
- R4: A cell that contains no pulse is reported as `bitData` = 0.
- R5: `bitValid` is high for exactly one clock per cell. With no jitter, consecutive strobes are `CELL_CLKS` clocks apart. With re-centring, the gap always stays within `CELL_CLKS` ± `TOL_CLKS`.
- R6: A pulse whose rising edge falls within ±`TOL_CLKS` clocks of its nominal position decodes as 1 and raises no error.
- R7: A pulse whose edge falls outside the window, at in-cell phase `HALF-TOL_CLKS-1` or `HALF+TOL_CLKS+1` (where `HALF` = `CELL_CLKS`/2), raises `pulseErr` for exactly one clock. That cell decodes as 0, and the grid is not moved.
- R8: A run of pulses that each drift by the full tolerance in the same direction, relative to the previous pulse, is decoded as all 1s with no error.
- R9: While `enable` is low, no strobe and no error are produced and the grid is released. After `enable` returns high, the next pulse relocks the grid and decodes as 1, following the R3 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable; low releases the grid and silences outputs |
| rxPulse | input | 1 | Asynchronous pulse-coded receive line |
| bitValid | output | 1 | One-clock strobe at each cell end |
| bitData | output | 1 | Decoded bit of the cell, valid with `bitValid` |
| pulseErr | output | 1 | One-clock flag for a pulse outside the tolerance window |

## Verification
The assertions check, on every cycle, the properties that hold in any trace:
- strobes are never back to back, and the gap between them stays within the jittered cell length;
- the error flag lasts one clock;
- outputs stay quiet while disabled or unlocked;
- disabling the block releases the grid.

Only the bench scenarios can show that a specific bit pattern comes out in order, that jittered and drifting pulses still decode as 1, that an out-of-window pulse turns its cell into a 0, and that the first strobe appears at the stated latency.

// File: rtl/rxDipulsePkg.sv
package rxDipulsePkg;

  // Strobes from control to the grid datapath
  typedef struct packed {
    logic unlock;    // release grid, park phase
    logic lock;      // first pulse: start grid at mid-cell
    logic recentre;  // in-window pulse: pull grid back to mid-cell
  } gridCtrl_t;

endpackage

// File: rtl/rxDipulseDatapath.sv
module rxDipulseDatapath
  import rxDipulsePkg::*;
#(
  parameter int CELL_CLKS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PH_W       = $clog2(CELL_CLKS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxPulse,
  input  gridCtrl_t       gridCtrl,
  output logic            rxEdge,
  output logic [PH_W-1:0] phase,
  output logic            locked
);

  localparam int HALF = CELL_CLKS / 2;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CELL_CLKS - 1);
  localparam logic [PH_W-1:0] PH_AFTER = PH_W'(HALF + 1);

  // Synchronizer chain plus one history stage for edge detection
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= rxPulse;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  assign rxEdge = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Cell grid: phase counter runs only while locked
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b0;
      phase  <= '0;
    end else if (gridCtrl.unlock) begin
      locked <= 1'b0;
      phase  <= '0;
    end else if (gridCtrl.lock || gridCtrl.recentre) begin
      locked <= 1'b1;
      phase  <= PH_AFTER;
    end else if (locked) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  // R9: releasing the grid takes effect on the next clock
  a_r9_unlock_clears: assert property (@(posedge clk) disable iff (!rstN)
    gridCtrl.unlock |=> !locked);

  // R2: an idle grid keeps its phase parked
  a_r2_idle_phase: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !gridCtrl.lock && !gridCtrl.recentre) |=> (phase == '0));

endmodule

// File: rtl/rxDipulseControl.sv
module rxDipulseControl
  import rxDipulsePkg::*;
#(
  parameter int CELL_CLKS = 8,
  parameter int TOL_CLKS  = 2,
  localparam int PH_W     = $clog2(CELL_CLKS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            rxEdge,
  input  logic            locked,
  input  logic [PH_W-1:0] phase,
  output gridCtrl_t       gridCtrl,
  output logic            bitValid,
  output logic            bitData,
  output logic            pulseErr
);

  localparam int HALF = CELL_CLKS / 2;
  localparam logic [PH_W-1:0] WIN_LO  = PH_W'(HALF - TOL_CLKS);
  localparam logic [PH_W-1:0] WIN_HI  = PH_W'(HALF + TOL_CLKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_CLKS - 1);

  logic cellBit;
  logic inWin;
  logic cellEnd;
  logic errNow;
  logic edgeLocked;

  always_comb begin
    inWin      = (phase >= WIN_LO) && (phase <= WIN_HI);
    edgeLocked = enable && rxEdge && locked;
    cellEnd    = enable && locked && (phase == PH_LAST);
    errNow     = edgeLocked && !inWin;

    gridCtrl.unlock   = !enable;
    gridCtrl.lock     = enable && rxEdge && !locked;
    gridCtrl.recentre = edgeLocked && inWin && !cellBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      cellBit  <= 1'b0;
      bitValid <= 1'b0;
      bitData  <= 1'b0;
      pulseErr <= 1'b0;
    end else begin
      bitValid <= cellEnd;
      pulseErr <= errNow;
      if (cellEnd) bitData <= cellBit;

      if (gridCtrl.lock)                cellBit <= 1'b1;
      else if (cellEnd)                 cellBit <= 1'b0;
      else if (edgeLocked && inWin)     cellBit <= 1'b1;
    end
  end

  // Checker state: clocks since the previous strobe
  localparam int GAP_MAX = CELL_CLKS + TOL_CLKS + 2;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic [GAP_W-1:0] gapCnt;
  logic             seenValid;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      gapCnt    <= '0;
      seenValid <= 1'b0;
    end else if (bitValid) begin
      gapCnt    <= GAP_W'(1);
      seenValid <= 1'b1;
    end else if (gapCnt != GAP_W'(GAP_MAX)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R5: one strobe per cell, never back to back
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R5: cell length stays within the jitter allowance
  a_r5_gap_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && seenValid) |->
      (gapCnt >= GAP_W'(CELL_CLKS - TOL_CLKS)) && (gapCnt <= GAP_W'(CELL_CLKS + TOL_CLKS)));

  // R7: error flag lasts a single clock
  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    pulseErr |=> !pulseErr);

  // R9: disabled receiver is silent
  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!bitValid && !pulseErr));

  // R2: no output activity before the grid is locked
  a_r2_unlocked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> (!bitValid && !pulseErr));

endmodule

// File: rtl/rxDipulseSampler.sv
module rxDipulseSampler
  import rxDipulsePkg::*;
#(
  parameter int CELL_CLKS   = 8,
  parameter int TOL_CLKS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic rxPulse,
  output logic bitValid,
  output logic bitData,
  output logic pulseErr
);

  localparam int PH_W = $clog2(CELL_CLKS);

  gridCtrl_t       gridCtrl;
  logic            rxEdge;
  logic            locked;
  logic [PH_W-1:0] phase;

  rxDipulseDatapath #(
    .CELL_CLKS  (CELL_CLKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .rxPulse (rxPulse),
    .gridCtrl(gridCtrl),
    .rxEdge  (rxEdge),
    .phase   (phase),
    .locked  (locked)
  );

  rxDipulseControl #(
    .CELL_CLKS(CELL_CLKS),
    .TOL_CLKS (TOL_CLKS)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .rxEdge  (rxEdge),
    .locked  (locked),
    .phase   (phase),
    .gridCtrl(gridCtrl),
    .bitValid(bitValid),
    .bitData (bitData),
    .pulseErr(pulseErr)
  );

endmodule

// File: tb/rxDipulseSampler_bench.sv
`timescale 1ns/1ps
module rxDipulseSampler_bench;

  localparam int CELL = 8;
  localparam int TOL  = 2;
  localparam int LAT  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic rxPulse = 1'b0;
  logic bitValid, bitData, pulseErr;

  rxDipulseSampler u_rxDipulseSampler (
    .clk(clk), .rstN(rstN), .enable(enable), .rxPulse(rxPulse),
    .bitValid(bitValid), .bitData(bitData), .pulseErr(pulseErr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  int gotBits[0:255];
  int validCyc[0:255];
  int gotN = 0;
  int errN = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (bitValid && gotN < 256) begin
        gotBits[gotN] = int'(bitData);
        validCyc[gotN] = cyc;
        gotN = gotN + 1;
      end
      if (pulseErr) errN = errN + 1;
    end
  end

  int txBit[0:63];
  int txJit[0:63];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulseAt(input int t);
    waitUntil(t);
    rxPulse = 1'b1;
    repeat (2) @(negedge clk);
    rxPulse = 1'b0;
  endtask

  task automatic restart();
    enable = 1'b0;
    repeat (3) @(negedge clk);
    gotN = 0;
    errN = 0;
    enable = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Runs cells 0..n-1; cell 0 is always the locking pulse
  task automatic runSeq(input int n, input string req, input bit checkGap);
    int expB[0:63];
    int base, baseIdx, t0, nErr, jit;
    restart();
    t0 = cyc + 1;
    base = t0;
    baseIdx = 0;
    nErr = 0;
    expB[0] = 1;
    pulseAt(t0);
    for (int i = 1; i < n; i++) begin
      expB[i] = 0;
      if (txBit[i] != 0) begin
        jit = txJit[i];
        pulseAt(base + CELL * (i - baseIdx) + jit);
        if (jit >= -TOL && jit <= TOL) begin
          base = base + CELL * (i - baseIdx) + jit;
          baseIdx = i;
          expB[i] = 1;
        end else begin
          nErr++;
        end
      end
    end
    waitUntil(base + CELL * (n - baseIdx) + 12);
    chk(gotN >= n, {req, " strobe count"}, gotN, n);
    for (int i = 0; i < n; i++)
      chk(gotBits[i] == expB[i], {req, " cell bit"}, gotBits[i], expB[i]);
    chk(errN == nErr, {req, " error count"}, errN, nErr);
    chk(validCyc[0] - t0 == LAT, "R3 first strobe latency", validCyc[0] - t0, LAT);
    if (checkGap)
      for (int i = 1; i < n; i++)
        chk(validCyc[i] - validCyc[i-1] == CELL, "R5 strobe spacing",
            validCyc[i] - validCyc[i-1], CELL);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearTx();
    for (int i = 0; i < 64; i++) begin
      txBit[i] = 0;
      txJit[i] = 0;
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(!bitValid, "R1 bitValid in reset", int'(bitValid), 0);
    chk(!bitData,  "R1 bitData in reset",  int'(bitData), 0);
    chk(!pulseErr, "R1 pulseErr in reset", int'(pulseErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!bitValid && !bitData && !pulseErr, "R1 outputs after reset",
        int'({bitValid, bitData, pulseErr}), 0);
  endtask

  task automatic testIdle();
    restart();
    repeat (30) @(negedge clk);
    chk(gotN == 0, "R2 no strobe before lock", gotN, 0);
    chk(errN == 0, "R2 no error before lock", errN, 0);
    enable = 1'b0;
  endtask

  task automatic testPattern();
    clearTx();
    txBit[2] = 1; txBit[3] = 1; txBit[6] = 1; txBit[8] = 1; txBit[9] = 1;
    runSeq(11, "R4 pattern", 1'b1);
  endtask

  task automatic testJitter();
    clearTx();
    for (int i = 1; i < 12; i++) txBit[i] = (i % 3 != 0) ? 1 : 0;
    txJit[1] = -2; txJit[2] = 2; txJit[4] = -1; txJit[5] = 1;
    txJit[7] = 2; txJit[8] = -2; txJit[10] = 0; txJit[11] = -2;
    runSeq(12, "R6 jitter", 1'b0);
  endtask

  task automatic testOutOfWindow();
    clearTx();
    txBit[1] = 1;
    txBit[2] = 1; txJit[2] = 3;
    txBit[3] = 1;
    txBit[4] = 1; txJit[4] = -3;
    txBit[5] = 1;
    runSeq(7, "R7 out of window", 1'b0);
  endtask

  task automatic testDrift();
    clearTx();
    for (int i = 1; i < 24; i++) begin txBit[i] = 1; txJit[i] = 2; end
    runSeq(24, "R8 late drift", 1'b0);
    clearTx();
    for (int i = 1; i < 24; i++) begin txBit[i] = 1; txJit[i] = -2; end
    runSeq(24, "R8 early drift", 1'b0);
  endtask

  task automatic testDisable();
    int snapN, snapE, t1;
    restart();
    pulseAt(cyc + 1);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    snapN = gotN;
    snapE = errN;
    chk(snapN >= 2, "R9 strobes before disable", snapN, 2);
    for (int k = 0; k < 4; k++) pulseAt(cyc + 5 + k);
    repeat (12) @(negedge clk);
    chk(gotN == snapN, "R9 no strobe while disabled", gotN, snapN);
    chk(errN == snapE, "R9 no error while disabled", errN, snapE);
    enable = 1'b1;
    repeat (15) @(negedge clk);
    chk(gotN == snapN, "R9 unlocked after re-enable", gotN, snapN);
    t1 = cyc + 1;
    pulseAt(t1);
    waitUntil(t1 + LAT + 1);
    chk(gotN == snapN + 1, "R9 relock strobe count", gotN, snapN + 1);
    chk(gotBits[snapN] == 1, "R9 relock bit", gotBits[snapN], 1);
    chk(validCyc[snapN] - t1 == LAT, "R9 relock latency", validCyc[snapN] - t1, LAT);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    testReset();
    testIdle();
    testPattern();
    testJitter();
    testOutOfWindow();
    testDrift();
    testDisable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule